// File: doc/BRIEF.md
# Two-Stage Virtual Path / Virtual Circuit Header Translator

This block rewrites the routing fields of cell headers at a switch input. Every lookup request carries an incoming virtual path number and virtual circuit number. The block answers with three things: the outgoing path number, the outgoing circuit number and a bit-mapped vector of destination ports. The answer comes from a chain of two table reads that are pipelined behind each other.

The first read uses the incoming path number as its index and returns a path entry. A path entry marked as path-level finishes the translation by itself. It gives the outgoing path number and the destination vector, and the incoming circuit number passes through unchanged. A path entry marked as circuit-level gives a base offset instead. The second read then uses the low bits of the incoming circuit number plus that base as its index into the circuit table, and the circuit entry gives all three outputs. The path table has one entry for every possible path number. The circuit table's depth is set by a parameter, which should follow the number of circuits the switch must support.

Connection setup and teardown reach the tables through two write ports, one for each table. These writes are independent of the lookup stream. The block accepts one request per clock and returns results in request order after a fixed delay.

Top module: `vcx_xlate`

## Requirements
- R1: While reset is high and in the cycle after it is released, `res_valid` is 0 and every other result output is 0.
- R2: A request presented with `req_valid` high in cycle n produces `res_valid` high in cycle n+2 and in no other cycle. Requests may arrive on back-to-back cycles, and their results come out in the same order.
- R3: The path table is indexed by `req_vpi`. Each path entry has a valid bit and a mode bit, where mode 1 means path-level. A valid path-level entry gives `res_path`=1, `res_miss`=0, the entry's outgoing path number and destination vector, and `res_vci` equal to the request's `req_vci`.
- R4: A valid path entry with mode 0 (circuit-level) gives a circuit-table index. That index is the low `VC_AW` bits of `req_vci` plus the entry's base, taken modulo the circuit table depth, so the sum wraps around. A valid circuit entry at that index gives `res_path`=0, `res_miss`=0 and the entry's outgoing path number, circuit number and destination vector.
- R5: If the path entry is invalid, the result has `res_miss`=1, `res_path`=0, and a zero destination vector, path number and circuit number.
- R6: If a circuit-level lookup lands on an invalid circuit entry, the result has `res_miss`=1, `res_path`=0, and a zero destination vector, path number and circuit number.
- R7: A table write in cycle n is seen by every lookup issued in cycle n+1 or later. This applies to setup, overwrite and teardown (writing the valid bit as 0).
- R8: In every cycle where `res_valid` is 0, `res_miss`, `res_path`, `res_vpi`, `res_vci` and `res_dvec` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A lookup request is present |
| req_vpi | input | VPI_W | Incoming path number |
| req_vci | input | VCI_W | Incoming circuit number |
| vp_wr_en | input | 1 | Write strobe for the path table |
| vp_wr_vpi | input | VPI_W | Path table address |
| vp_wr_valid | input | 1 | Valid bit to write |
| vp_wr_path | input | 1 | Mode bit: 1 = path-level, 0 = circuit-level |
| vp_wr_out_vpi | input | VPI_W | Outgoing path number (path-level) |
| vp_wr_dvec | input | PORTS | Destination vector (path-level) |
| vp_wr_base | input | VC_AW | Circuit table base (circuit-level) |
| vc_wr_en | input | 1 | Write strobe for the circuit table |
| vc_wr_idx | input | VC_AW | Circuit table address |
| vc_wr_valid | input | 1 | Valid bit to write |
| vc_wr_out_vpi | input | VPI_W | Outgoing path number |
| vc_wr_out_vci | input | VCI_W | Outgoing circuit number |
| vc_wr_dvec | input | PORTS | Destination vector |
| res_valid | output | 1 | A result is present |
| res_miss | output | 1 | Translation failed on an invalid entry |
| res_path | output | 1 | Result came from a path-level entry |
| res_vpi | output | VPI_W | Outgoing path number |
| res_vci | output | VCI_W | Outgoing circuit number |
| res_dvec | output | PORTS | Destination port vector |

## Verification
The latency and pass-through properties look two cycles back at `req_valid` and `req_vci`. They therefore assume that `req_valid` stays low while reset is high. The stimulus keeps it low during reset and for the cycles that follow. The properties also assume that no write to the circuit table lands while a lookup that depends on the same entry is between its two reads. For that reason the stimulus never mixes table writes with lookups that are in flight. It drains the pipeline before every write batch. The only exception is the directed case of a write followed on the next cycle by a lookup.

// File: rtl/vcx_pkg.sv
package vcx_pkg;

  // Mode bit stored in each path table entry.
  typedef enum logic {
    XL_CIRCUIT = 1'b0,
    XL_PATH    = 1'b1
  } xl_mode_e;

endpackage

// File: rtl/vcx_vp_stage.sv
// Stage 1: path table read, indexed by the incoming path number.
module vcx_vp_stage #(
  parameter int VPI_W = 8,
  parameter int VCI_W = 16,
  parameter int ENT_W = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VPI_W-1:0] req_vpi,
  input  logic [VCI_W-1:0] req_vci,
  input  logic             we,
  input  logic [VPI_W-1:0] waddr,
  input  logic [ENT_W-1:0] wdata,
  output logic             s1_valid,
  output logic [VCI_W-1:0] s1_vci,
  output logic [ENT_W-1:0] s1_ent
);
  localparam int DEPTH = 2 ** VPI_W;

  logic [ENT_W-1:0] mem [DEPTH];

  // Read-first block RAM: a write is seen by a read one cycle later.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    s1_ent <= mem[req_vpi];
    s1_vci <= req_vci;
  end

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= req_valid;
  end

  // R2: stage 1 follows the request by one cycle.
  p_s1_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    s1_valid == $past(req_valid));

  // R2: the circuit number travels with its request.
  p_s1_vci_carried_r2: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> s1_vci == $past(req_vci));

endmodule

// File: rtl/vcx_vc_stage.sv
// Stage 2: decode the path entry, form the circuit index and read the circuit table.
module vcx_vc_stage #(
  parameter int VPI_W    = 8,
  parameter int VCI_W    = 16,
  parameter int VC_AW    = 8,
  parameter int PORTS    = 5,
  parameter int VP_ENT_W = 23,
  parameter int VC_ENT_W = 30
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s1_valid,
  input  logic [VCI_W-1:0]    s1_vci,
  input  logic [VP_ENT_W-1:0] s1_ent,
  input  logic                we,
  input  logic [VC_AW-1:0]    waddr,
  input  logic [VC_ENT_W-1:0] wdata,
  output logic                s2_valid,
  output logic                s2_vp_ok,
  output logic                s2_path,
  output logic [VPI_W-1:0]    s2_vpi,
  output logic [PORTS-1:0]    s2_dvec,
  output logic [VCI_W-1:0]    s2_vci,
  output logic [VC_ENT_W-1:0] s2_vc_ent
);
  localparam int DEPTH  = 2 ** VC_AW;
  localparam int DV_LSB = VC_AW;
  localparam int VP_LSB = VC_AW + PORTS;

  logic [VC_ENT_W-1:0] mem [DEPTH];
  logic [VC_AW-1:0]    base;
  logic [VC_AW-1:0]    idx;

  assign base = s1_ent[VC_AW-1:0];
  assign idx  = s1_vci[VC_AW-1:0] + base;   // wraps modulo the table depth

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    s2_vc_ent <= mem[idx];
    s2_vp_ok  <= s1_ent[VP_ENT_W-1];
    s2_path   <= s1_ent[VP_ENT_W-2];
    s2_vpi    <= s1_ent[VP_LSB +: VPI_W];
    s2_dvec   <= s1_ent[DV_LSB +: PORTS];
    s2_vci    <= s1_vci;
  end

  always_ff @(posedge clk) begin
    if (rst) s2_valid <= 1'b0;
    else     s2_valid <= s1_valid;
  end

  // R2: stage 2 follows stage 1 by one cycle.
  p_s2_follows_s1_r2: assert property (@(posedge clk) disable iff (rst)
    s2_valid == $past(s1_valid));

  // R3: the incoming circuit number is kept for path-level pass-through.
  p_s2_vci_carried_r3: assert property (@(posedge clk) disable iff (rst)
    s2_valid |-> s2_vci == $past(s1_vci));

endmodule

// File: rtl/vcx_xlate.sv
module vcx_xlate
  import vcx_pkg::*;
#(
  parameter int VPI_W = 8,
  parameter int VCI_W = 16,
  parameter int VC_AW = 8,
  parameter int PORTS = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VPI_W-1:0] req_vpi,
  input  logic [VCI_W-1:0] req_vci,
  input  logic             vp_wr_en,
  input  logic [VPI_W-1:0] vp_wr_vpi,
  input  logic             vp_wr_valid,
  input  logic             vp_wr_path,
  input  logic [VPI_W-1:0] vp_wr_out_vpi,
  input  logic [PORTS-1:0] vp_wr_dvec,
  input  logic [VC_AW-1:0] vp_wr_base,
  input  logic             vc_wr_en,
  input  logic [VC_AW-1:0] vc_wr_idx,
  input  logic             vc_wr_valid,
  input  logic [VPI_W-1:0] vc_wr_out_vpi,
  input  logic [VCI_W-1:0] vc_wr_out_vci,
  input  logic [PORTS-1:0] vc_wr_dvec,
  output logic             res_valid,
  output logic             res_miss,
  output logic             res_path,
  output logic [VPI_W-1:0] res_vpi,
  output logic [VCI_W-1:0] res_vci,
  output logic [PORTS-1:0] res_dvec
);
  // Path entry layout:    {valid, mode, out_vpi, dvec, base}
  // Circuit entry layout: {valid, out_vpi, out_vci, dvec}
  localparam int VP_ENT_W = 2 + VPI_W + PORTS + VC_AW;
  localparam int VC_ENT_W = 1 + VPI_W + VCI_W + PORTS;

  logic [VP_ENT_W-1:0] vp_wdata;
  logic [VC_ENT_W-1:0] vc_wdata;
  logic                s1_valid;
  logic [VCI_W-1:0]    s1_vci;
  logic [VP_ENT_W-1:0] s1_ent;
  logic                s2_valid, s2_vp_ok, s2_path;
  logic [VPI_W-1:0]    s2_vpi;
  logic [PORTS-1:0]    s2_dvec;
  logic [VCI_W-1:0]    s2_vci;
  logic [VC_ENT_W-1:0] s2_vc_ent;
  xl_mode_e            mode;

  assign vp_wdata = {vp_wr_valid, vp_wr_path, vp_wr_out_vpi, vp_wr_dvec, vp_wr_base};
  assign vc_wdata = {vc_wr_valid, vc_wr_out_vpi, vc_wr_out_vci, vc_wr_dvec};

  vcx_vp_stage #(.VPI_W(VPI_W), .VCI_W(VCI_W), .ENT_W(VP_ENT_W)) i_vp (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vpi(req_vpi),
    .req_vci(req_vci), .we(vp_wr_en), .waddr(vp_wr_vpi), .wdata(vp_wdata),
    .s1_valid(s1_valid), .s1_vci(s1_vci), .s1_ent(s1_ent)
  );

  vcx_vc_stage #(.VPI_W(VPI_W), .VCI_W(VCI_W), .VC_AW(VC_AW), .PORTS(PORTS),
                 .VP_ENT_W(VP_ENT_W), .VC_ENT_W(VC_ENT_W)) i_vc (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_vci(s1_vci), .s1_ent(s1_ent),
    .we(vc_wr_en), .waddr(vc_wr_idx), .wdata(vc_wdata),
    .s2_valid(s2_valid), .s2_vp_ok(s2_vp_ok), .s2_path(s2_path),
    .s2_vpi(s2_vpi), .s2_dvec(s2_dvec), .s2_vci(s2_vci), .s2_vc_ent(s2_vc_ent)
  );

  assign mode = xl_mode_e'(s2_path);

  // One level of selection after the stage-2 registers.
  always_comb begin
    res_valid = s2_valid;
    res_miss  = 1'b0;
    res_path  = 1'b0;
    res_vpi   = '0;
    res_vci   = '0;
    res_dvec  = '0;
    if (s2_valid) begin
      if (!s2_vp_ok) begin
        res_miss = 1'b1;
      end else if (mode == XL_PATH) begin
        res_path = 1'b1;
        res_vpi  = s2_vpi;
        res_vci  = s2_vci;
        res_dvec = s2_dvec;
      end else if (!s2_vc_ent[VC_ENT_W-1]) begin
        res_miss = 1'b1;
      end else begin
        res_vpi  = s2_vc_ent[PORTS+VCI_W +: VPI_W];
        res_vci  = s2_vc_ent[PORTS +: VCI_W];
        res_dvec = s2_vc_ent[PORTS-1:0];
      end
    end
  end

  // R2: a result appears exactly two cycles after its request.
  p_latency_fwd_r2: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid, 2) |-> res_valid);
  p_latency_bwd_r2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(req_valid, 2));

  // R3: a path-level hit returns the request's own circuit number.
  p_path_passthru_r3: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_path) |-> res_vci == $past(req_vci, 2));

  // R5, R6: a miss never carries a destination or a path flag.
  p_miss_empty_r5: assert property (@(posedge clk) disable iff (rst)
    res_miss |-> (res_dvec == '0 && !res_path && res_vpi == '0 && res_vci == '0));

  // R8: the outputs stay quiet while no result is present.
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_miss && !res_path && res_dvec == '0 &&
                    res_vpi == '0 && res_vci == '0));

endmodule

// File: tb/test_vcx_xlate.sv
module test_vcx_xlate;
  localparam int VPI_W = 8, VCI_W = 16, VC_AW = 8, PORTS = 5;

  typedef struct packed {
    logic             v;
    logic             miss;
    logic             path;
    logic [VPI_W-1:0] vpi;
    logic [VCI_W-1:0] vci;
    logic [PORTS-1:0] dvec;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [VPI_W-1:0] req_vpi = '0;
  logic [VCI_W-1:0] req_vci = '0;
  logic vp_wr_en = 1'b0, vp_wr_valid = 1'b0, vp_wr_path = 1'b0;
  logic [VPI_W-1:0] vp_wr_vpi = '0, vp_wr_out_vpi = '0;
  logic [PORTS-1:0] vp_wr_dvec = '0;
  logic [VC_AW-1:0] vp_wr_base = '0;
  logic vc_wr_en = 1'b0, vc_wr_valid = 1'b0;
  logic [VC_AW-1:0] vc_wr_idx = '0;
  logic [VPI_W-1:0] vc_wr_out_vpi = '0;
  logic [VCI_W-1:0] vc_wr_out_vci = '0;
  logic [PORTS-1:0] vc_wr_dvec = '0;
  logic res_valid, res_miss, res_path;
  logic [VPI_W-1:0] res_vpi;
  logic [VCI_W-1:0] res_vci;
  logic [PORTS-1:0] res_dvec;

  always #10 clk = ~clk;   // 50 MHz

  vcx_xlate #(.VPI_W(VPI_W), .VCI_W(VCI_W), .VC_AW(VC_AW), .PORTS(PORTS)) i_vcx_xlate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vpi(req_vpi), .req_vci(req_vci),
    .vp_wr_en(vp_wr_en), .vp_wr_vpi(vp_wr_vpi), .vp_wr_valid(vp_wr_valid),
    .vp_wr_path(vp_wr_path), .vp_wr_out_vpi(vp_wr_out_vpi), .vp_wr_dvec(vp_wr_dvec),
    .vp_wr_base(vp_wr_base), .vc_wr_en(vc_wr_en), .vc_wr_idx(vc_wr_idx),
    .vc_wr_valid(vc_wr_valid), .vc_wr_out_vpi(vc_wr_out_vpi),
    .vc_wr_out_vci(vc_wr_out_vci), .vc_wr_dvec(vc_wr_dvec),
    .res_valid(res_valid), .res_miss(res_miss), .res_path(res_path),
    .res_vpi(res_vpi), .res_vci(res_vci), .res_dvec(res_dvec)
  );

  // Table model, updated as the writes are issued.
  logic             m_vp_v [256];
  logic             m_vp_p [256];
  logic [VPI_W-1:0] m_vp_o [256];
  logic [PORTS-1:0] m_vp_d [256];
  logic [VC_AW-1:0] m_vp_b [256];
  logic             m_vc_v [256];
  logic [VPI_W-1:0] m_vc_p [256];
  logic [VCI_W-1:0] m_vc_c [256];
  logic [PORTS-1:0] m_vc_d [256];

  int checks = 0, fails = 0;
  bit done = 1'b0;
  exp_t e1 = '0, e2 = '0;
  string t1 = "R8", t2 = "R8";

  // Staged writes for the next cycle.
  bit s_vp = 0, s_vc = 0;
  logic [7:0] s_vp_a, s_vp_o, s_vc_a, s_vc_o;
  logic s_vp_v, s_vp_p, s_vc_v;
  logic [4:0] s_vp_d, s_vc_d;
  logic [7:0] s_vp_b;
  logic [15:0] s_vc_c;

  function automatic exp_t predict(input logic [7:0] vpi, input logic [15:0] vci);
    exp_t e = '0;
    logic [7:0] idx;
    e.v = 1'b1;
    if (!m_vp_v[vpi]) e.miss = 1'b1;
    else if (m_vp_p[vpi]) begin
      e.path = 1'b1; e.vpi = m_vp_o[vpi]; e.vci = vci; e.dvec = m_vp_d[vpi];
    end else begin
      idx = vci[7:0] + m_vp_b[vpi];
      if (!m_vc_v[idx]) e.miss = 1'b1;
      else begin e.vpi = m_vc_p[idx]; e.vci = m_vc_c[idx]; e.dvec = m_vc_d[idx]; end
    end
    return e;
  endfunction

  task automatic check_out(input exp_t e, input string tag);
    exp_t a;
    a = '{v: res_valid, miss: res_miss, path: res_path, vpi: res_vpi,
          vci: res_vci, dvec: res_dvec};
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s: actual v=%0b miss=%0b path=%0b vpi=%h vci=%h dvec=%b expected v=%0b miss=%0b path=%0b vpi=%h vci=%h dvec=%b",
               tag, a.v, a.miss, a.path, a.vpi, a.vci, a.dvec,
               e.v, e.miss, e.path, e.vpi, e.vci, e.dvec);
    end
  endtask

  // One clock: check the result of the request from two cycles back, then drive.
  task automatic cycle(input bit rv, input logic [7:0] vpi, input logic [15:0] vci,
                       input string tag);
    @(negedge clk);
    check_out(e2, t2);
    e2 = e1; t2 = t1;
    e1 = rv ? predict(vpi, vci) : '0;
    t1 = rv ? tag : "R8";
    req_valid = rv; req_vpi = vpi; req_vci = vci;
    vp_wr_en = s_vp; vc_wr_en = s_vc;
    if (s_vp) begin
      vp_wr_vpi = s_vp_a; vp_wr_valid = s_vp_v; vp_wr_path = s_vp_p;
      vp_wr_out_vpi = s_vp_o; vp_wr_dvec = s_vp_d; vp_wr_base = s_vp_b;
      m_vp_v[s_vp_a] = s_vp_v; m_vp_p[s_vp_a] = s_vp_p; m_vp_o[s_vp_a] = s_vp_o;
      m_vp_d[s_vp_a] = s_vp_d; m_vp_b[s_vp_a] = s_vp_b;
    end
    if (s_vc) begin
      vc_wr_idx = s_vc_a; vc_wr_valid = s_vc_v; vc_wr_out_vpi = s_vc_o;
      vc_wr_out_vci = s_vc_c; vc_wr_dvec = s_vc_d;
      m_vc_v[s_vc_a] = s_vc_v; m_vc_p[s_vc_a] = s_vc_o;
      m_vc_c[s_vc_a] = s_vc_c; m_vc_d[s_vc_a] = s_vc_d;
    end
    s_vp = 0; s_vc = 0;
  endtask

  task automatic put_vp(input logic [7:0] a, input logic v, input logic p,
                        input logic [7:0] o, input logic [4:0] d, input logic [7:0] b);
    s_vp = 1; s_vp_a = a; s_vp_v = v; s_vp_p = p; s_vp_o = o; s_vp_d = d; s_vp_b = b;
  endtask

  task automatic put_vc(input logic [7:0] a, input logic v, input logic [7:0] o,
                        input logic [15:0] c, input logic [4:0] d);
    s_vc = 1; s_vc_a = a; s_vc_v = v; s_vc_o = o; s_vc_c = c; s_vc_d = d;
  endtask

  task automatic drain();
    cycle(0, '0, '0, "R8");
    cycle(0, '0, '0, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet while reset is held.
    check_out('0, "R1");
    rst = 1'b0;
    @(negedge clk);
    check_out('0, "R1");

    // Clear both tables, then fill them with random contents (fixed seed).
    void'($urandom(32'h1ce5));
    for (int i = 0; i < 256; i++) begin
      put_vp(i[7:0], 1'b0, 1'b0, '0, '0, '0);
      put_vc(i[7:0], 1'b0, '0, '0, '0);
      cycle(0, '0, '0, "R8");
    end
    for (int i = 0; i < 256; i++) begin
      put_vp(i[7:0], ($urandom % 4) != 0, $urandom % 2, 8'($urandom), 5'($urandom),
             8'($urandom));
      put_vc(i[7:0], ($urandom % 4) != 0, 8'($urandom), 16'($urandom), 5'($urandom));
      cycle(0, '0, '0, "R8");
    end
    drain();

    // R2: back-to-back random lookups, results in request order.
    for (int i = 0; i < 400; i++)
      cycle(1, 8'($urandom), 16'($urandom), "R2");
    drain();

    // R3: path-level entry, circuit number passes through.
    put_vp(8'd5, 1'b1, 1'b1, 8'h3C, 5'b00101, 8'h00);
    cycle(0, '0, '0, "R8");
    cycle(1, 8'd5, 16'hBEEF, "R3");
    cycle(1, 8'd5, 16'h0001, "R3");
    drain();

    // R4: circuit-level lookup whose index wraps: (0x0A + 250) mod 256 = 4.
    put_vp(8'd9, 1'b1, 1'b0, 8'h00, 5'b00000, 8'd250);
    put_vc(8'd4, 1'b1, 8'h77, 16'h4321, 5'b10010);
    cycle(0, '0, '0, "R8");
    cycle(1, 8'd9, 16'h120A, "R4");
    drain();

    // R5: invalid path entry.
    put_vp(8'd17, 1'b0, 1'b1, 8'hFF, 5'b11111, 8'h00);
    cycle(0, '0, '0, "R8");
    cycle(1, 8'd17, 16'h5555, "R5");
    drain();

    // R6: circuit-level lookup that lands on an invalid circuit entry.
    put_vp(8'd18, 1'b1, 1'b0, 8'h00, 5'b00000, 8'd3);
    put_vc(8'd13, 1'b0, 8'hAA, 16'hAAAA, 5'b11111);
    cycle(0, '0, '0, "R8");
    cycle(1, 8'd18, 16'h000A, "R6");
    drain();

    // R7: setup is seen by the lookup in the next cycle, then teardown is too.
    put_vc(8'd13, 1'b1, 8'h21, 16'h0BAD, 5'b01000);
    cycle(0, '0, '0, "R8");
    cycle(1, 8'd18, 16'h000A, "R7");
    drain();
    put_vp(8'd5, 1'b0, 1'b1, 8'h3C, 5'b00101, 8'h00);
    cycle(0, '0, '0, "R8");
    cycle(1, 8'd5, 16'h1234, "R7");
    drain();
    put_vp(8'd5, 1'b1, 1'b1, 8'h99, 5'b11000, 8'h00);
    cycle(0, '0, '0, "R8");
    cycle(1, 8'd5, 16'h7777, "R7");
    drain();

    // Second random burst with gaps in the request stream.
    for (int i = 0; i < 300; i++)
      cycle(($urandom % 3) != 0, 8'($urandom), 16'($urandom), "R2");
    drain();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule